// File: doc/BRIEF.md
# Page Protection Policy Controller

This block holds the byte-wide protection settings of a small linear memory. The memory has four 32-byte data pages at the bottom, an 8-byte control row above them, an 8-byte reserved row, and nothing beyond that. For any target address the block reports an access mode, a locked flag and a copy-block flag. A data page can be open, write-protected, or in bit-clear-only (EPROM-style) mode. Each setting is chosen by a magic value held in that page's control byte. Writing a magic value into a control byte also freezes that byte for good.

A master presents an address together with an optional write strobe and data byte. If the address falls in the control row and that byte is not frozen, the byte takes the new value on the next clock edge. All decisions are combinational from the address and the stored bytes. A separate preload port sets any control byte without regard to locks. It stands in for the values a non-volatile store would supply. A read port returns the stored byte at a control-row address.

Top module: `page_guard`

## Requirements
- R1: Addresses 0000h–007Fh are data; page number is address bits [6:5], and that page's mode comes from the control byte at 0080h + page number.
- R2: A page control value of 55h gives mode 01 (write-protect) with locked = 1; a value of AAh gives mode 10 (bit-clear-only) with locked = 0.
- R3: Any other page control value gives mode 00 (open) with locked = 0.
- R4: Control bytes 0080h–0084h that hold 55h or AAh report mode 11 with locked = 1, and a write strobe to them leaves the stored value unchanged. Otherwise they report mode 00 with locked = 0, and a write strobe stores wr_data on the next rising edge.
- R5: The byte at 0085h always reports mode 11 with locked = 1, and write strobes never change it.
- R6: When 0085h holds AAh, bytes 0086h and 0087h report mode 11 and locked = 1, and writes to them are ignored. For any other value they are open and writable.
- R7: Addresses 0088h–008Fh always report mode 11 with locked = 1 and read back 00h.
- R8: Addresses 0090h and above report mode 11, locked = 1 and copy_blk = 0.
- R9: When 0084h holds 55h or AAh, copy_blk = 1 for 0080h–008Fh and for every page in write-protect mode. copy_blk is 0 everywhere else, and 0 everywhere when 0084h holds any other value.
- R10: After synchronous reset, bytes 0080h–0084h, 0086h and 0087h hold 00h, and 0085h holds FACTORY_RST (default 55h).
- R11: A preload (ld_en) writes ld_data into control byte ld_sel (0 maps to 0080h … 7 to 0087h) on the next rising edge, regardless of locks. It takes priority over a simultaneous write strobe.
- R12: rd_data shows the stored byte for 0080h–0087h and 00h for all other addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Target address |
| wr_req | input | 1 | Write strobe for the target address |
| wr_data | input | 8 | Byte to store on a permitted control-row write |
| ld_en | input | 1 | Lock-bypassing preload strobe |
| ld_sel | input | 3 | Control byte selected for preload |
| ld_data | input | 8 | Preload value |
| mode | output | 2 | 00 open, 01 write-protect, 10 bit-clear-only, 11 locked/invalid |
| locked | output | 1 | Address cannot be written |
| copy_blk | output | 1 | Copy into this address is blocked |
| rd_data | output | 8 | Stored control byte at addr, else 00h |

## Verification
The bench builds the block with its defaults: four pages of 32 bytes, 8-byte rows, 16-bit addresses and a factory reset value of 55h. With a 16-bit address, every region edge can be reached: the ends of each page, the control-row edges, both ends of the reserved row, 0090h and FFFFh. The 55h factory default leaves the user bytes open at first. The bench then preloads AAh into the factory byte so that the user-byte lock can be seen flipping. The page control byte at 0082h is also driven from open to write-protect by an ordinary write strobe, to show the self-lock taking hold.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

    typedef enum logic [1:0] {
        MODE_OPEN  = 2'b00,
        MODE_WPROT = 2'b01,
        MODE_EPROM = 2'b10,
        MODE_LOCK  = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        RG_PAGE    = 2'b00,
        RG_CTRL    = 2'b01,
        RG_RSVD    = 2'b10,
        RG_INVALID = 2'b11
    } region_e;

    localparam logic [7:0] CODE_WP = 8'h55;
    localparam logic [7:0] CODE_EP = 8'hAA;

    function automatic logic is_magic(input logic [7:0] v);
        return (v == CODE_WP) || (v == CODE_EP);
    endfunction

    function automatic mode_e page_mode(input logic [7:0] v);
        if (v == CODE_WP)      return MODE_WPROT;
        else if (v == CODE_EP) return MODE_EPROM;
        else                   return MODE_OPEN;
    endfunction

endpackage

// File: rtl/ppc_decode.sv
module ppc_decode
    import ppc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PAGE_CNT   = 4,
    parameter int PAGE_BYTES = 32,
    parameter int ROW_BYTES  = 8,
    localparam int REG_CNT   = PAGE_CNT + 4,
    localparam int RI_W      = $clog2(REG_CNT),
    localparam int PG_W      = (PAGE_CNT > 1) ? $clog2(PAGE_CNT) : 1,
    localparam int PG_LSB    = $clog2(PAGE_BYTES)
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [PG_W-1:0]   page_idx,
    output logic [RI_W-1:0]   reg_idx
);
    localparam int REG_BASE = PAGE_CNT * PAGE_BYTES;
    localparam logic [ADDR_W-1:0] A_REG  = ADDR_W'(REG_BASE);
    localparam logic [ADDR_W-1:0] N_REG  = ADDR_W'(REG_CNT);
    localparam logic [ADDR_W-1:0] N_ROWS = ADDR_W'(2 * ROW_BYTES);

    logic [ADDR_W-1:0] off;

    always_comb begin
        off      = addr - A_REG;
        page_idx = addr[PG_LSB +: PG_W];
        reg_idx  = off[RI_W-1:0];
        if (addr < A_REG)        region = RG_PAGE;
        else if (off < N_REG)    region = RG_CTRL;
        else if (off < N_ROWS)   region = RG_RSVD;
        else                     region = RG_INVALID;
    end
endmodule

// File: rtl/ppc_regs.sv
module ppc_regs
    import ppc_pkg::*;
#(
    parameter int         PAGE_CNT    = 4,
    parameter logic [7:0] FACTORY_RST = 8'h55,
    localparam int        REG_CNT     = PAGE_CNT + 4,
    localparam int        RI_W        = $clog2(REG_CNT),
    localparam int        FACT_IDX    = PAGE_CNT + 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ld_en,
    input  logic [RI_W-1:0]            ld_sel,
    input  logic [7:0]                 ld_data,
    input  logic                       wr_en,
    input  logic [RI_W-1:0]            wr_sel,
    input  logic [7:0]                 wr_data,
    output logic [REG_CNT-1:0][7:0]    ctl
);
    for (genvar i = 0; i < REG_CNT; i++) begin : g_byte
        if (i == FACT_IDX) begin : g_fact
            always_ff @(posedge clk) begin
                if (rst)                                     ctl[i] <= FACTORY_RST;
                else if (ld_en && ld_sel == RI_W'(i))        ctl[i] <= ld_data;
            end
        end else begin : g_rw
            always_ff @(posedge clk) begin
                if (rst)                                     ctl[i] <= 8'h00;
                else if (ld_en && ld_sel == RI_W'(i))        ctl[i] <= ld_data;
                else if (wr_en && wr_sel == RI_W'(i))        ctl[i] <= wr_data;
            end
        end

        if (i <= PAGE_CNT) begin : g_selflock
            // R4: a magic control byte only changes through preload
            assert_selflock_R4: assert property (@(posedge clk) disable iff (rst)
                (is_magic(ctl[i]) && !ld_en) |=> (ctl[i] == $past(ctl[i])));
        end
    end

    // R5: factory byte moves only on preload
    assert_factory_fixed_R5: assert property (@(posedge clk) disable iff (rst)
        !ld_en |=> $stable(ctl[FACT_IDX]));
endmodule

// File: rtl/ppc_policy.sv
module ppc_policy
    import ppc_pkg::*;
#(
    parameter int  PAGE_CNT = 4,
    localparam int REG_CNT  = PAGE_CNT + 4,
    localparam int RI_W     = $clog2(REG_CNT),
    localparam int PG_W     = (PAGE_CNT > 1) ? $clog2(PAGE_CNT) : 1,
    localparam int COPY_IDX = PAGE_CNT,
    localparam int FACT_IDX = PAGE_CNT + 1
) (
    input  region_e                 region,
    input  logic [PG_W-1:0]         page_idx,
    input  logic [RI_W-1:0]         reg_idx,
    input  logic [REG_CNT-1:0][7:0] ctl,
    output mode_e                   mode,
    output logic                    locked,
    output logic                    copy_blk
);
    logic cp_on;

    always_comb begin
        cp_on    = is_magic(ctl[COPY_IDX]);
        mode     = MODE_LOCK;
        locked   = 1'b1;
        copy_blk = 1'b0;
        unique case (region)
            RG_PAGE: begin
                mode     = page_mode(ctl[page_idx]);
                locked   = (mode == MODE_WPROT);
                copy_blk = cp_on && (mode == MODE_WPROT);
            end
            RG_CTRL: begin
                if (reg_idx <= RI_W'(COPY_IDX))
                    locked = is_magic(ctl[reg_idx]);
                else if (reg_idx == RI_W'(FACT_IDX))
                    locked = 1'b1;
                else
                    locked = (ctl[FACT_IDX] == CODE_EP);
                mode     = locked ? MODE_LOCK : MODE_OPEN;
                copy_blk = cp_on;
            end
            RG_RSVD: begin
                copy_blk = cp_on;
            end
            default: begin
                copy_blk = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/page_guard.sv
module page_guard
    import ppc_pkg::*;
#(
    parameter int         ADDR_W      = 16,
    parameter int         PAGE_CNT    = 4,
    parameter int         PAGE_BYTES  = 32,
    parameter int         ROW_BYTES   = 8,
    parameter logic [7:0] FACTORY_RST = 8'h55,
    localparam int        REG_CNT     = PAGE_CNT + 4,
    localparam int        RI_W        = $clog2(REG_CNT),
    localparam int        PG_W        = (PAGE_CNT > 1) ? $clog2(PAGE_CNT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_req,
    input  logic [7:0]        wr_data,
    input  logic              ld_en,
    input  logic [RI_W-1:0]   ld_sel,
    input  logic [7:0]        ld_data,
    output logic [1:0]        mode,
    output logic              locked,
    output logic              copy_blk,
    output logic [7:0]        rd_data
);
    region_e                 region;
    logic [PG_W-1:0]         page_idx;
    logic [RI_W-1:0]         reg_idx;
    logic [REG_CNT-1:0][7:0] ctl;
    mode_e                   mode_q;
    logic                    wr_en;

    ppc_decode #(
        .ADDR_W(ADDR_W), .PAGE_CNT(PAGE_CNT),
        .PAGE_BYTES(PAGE_BYTES), .ROW_BYTES(ROW_BYTES)
    ) u_decode (
        .addr(addr), .region(region), .page_idx(page_idx), .reg_idx(reg_idx)
    );

    ppc_regs #(.PAGE_CNT(PAGE_CNT), .FACTORY_RST(FACTORY_RST)) u_regs (
        .clk(clk), .rst(rst),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .wr_en(wr_en), .wr_sel(reg_idx), .wr_data(wr_data),
        .ctl(ctl)
    );

    ppc_policy #(.PAGE_CNT(PAGE_CNT)) u_policy (
        .region(region), .page_idx(page_idx), .reg_idx(reg_idx), .ctl(ctl),
        .mode(mode_q), .locked(locked), .copy_blk(copy_blk)
    );

    assign wr_en   = wr_req && (region == RG_CTRL) && !locked;
    assign mode    = mode_q;
    assign rd_data = (region == RG_CTRL) ? ctl[reg_idx] : 8'h00;

    // R7: reserved row is never writable
    assert_rsvd_locked_R7: assert property (@(posedge clk) disable iff (rst)
        (region == RG_RSVD) |-> (mode_q == MODE_LOCK && locked && rd_data == 8'h00));

    // R8: out-of-map addresses are locked and never copy-blocked
    assert_invalid_locked_R8: assert property (@(posedge clk) disable iff (rst)
        (region == RG_INVALID) |-> (mode_q == MODE_LOCK && locked && !copy_blk));

    // R4: a permitted write lands on the next edge unless preloaded
    assert_write_lands_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ld_en) |=> (ctl[$past(reg_idx)] == $past(wr_data)));
endmodule

// File: tb/tb_page_guard.sv
`timescale 1ns/1ps
module tb_page_guard;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] addr;
    logic        wr_req;
    logic [7:0]  wr_data;
    logic        ld_en;
    logic [2:0]  ld_sel;
    logic [7:0]  ld_data;
    logic [1:0]  mode;
    logic        locked;
    logic        copy_blk;
    logic [7:0]  rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    page_guard dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_req(wr_req), .wr_data(wr_data),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .mode(mode), .locked(locked), .copy_blk(copy_blk), .rd_data(rd_data)
    );

    // {addr, mode, locked, copy_blk}; config p0=55 p1=AA p2=3C p3=00, 84h=00, 85h=55
    localparam logic [19:0] VEC [18] = '{
        {16'h0000, 2'b01, 1'b1, 1'b0},   // R1 R2 page0 WP
        {16'h001F, 2'b01, 1'b1, 1'b0},
        {16'h0020, 2'b10, 1'b0, 1'b0},   // R2 page1 EPROM
        {16'h003F, 2'b10, 1'b0, 1'b0},
        {16'h0040, 2'b00, 1'b0, 1'b0},   // R3 page2 3C
        {16'h007F, 2'b00, 1'b0, 1'b0},
        {16'h0080, 2'b11, 1'b1, 1'b0},   // R4
        {16'h0081, 2'b11, 1'b1, 1'b0},
        {16'h0082, 2'b00, 1'b0, 1'b0},
        {16'h0083, 2'b00, 1'b0, 1'b0},
        {16'h0084, 2'b00, 1'b0, 1'b0},
        {16'h0085, 2'b11, 1'b1, 1'b0},   // R5
        {16'h0086, 2'b00, 1'b0, 1'b0},   // R6
        {16'h0087, 2'b00, 1'b0, 1'b0},
        {16'h0088, 2'b11, 1'b1, 1'b0},   // R7
        {16'h008F, 2'b11, 1'b1, 1'b0},
        {16'h0090, 2'b11, 1'b1, 1'b0},   // R8
        {16'hFFFF, 2'b11, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, act, exp);
        end
    endtask

    task automatic look(input logic [15:0] a);
        @(negedge clk);
        addr = a;
        #1;
    endtask

    task automatic preload(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = s; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_req = 1'b1; wr_data = d;
        @(negedge clk);
        wr_req = 1'b0;
        #1;
    endtask

    task automatic finish_up();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    initial begin
        rst = 1'b1; addr = 16'h0; wr_req = 1'b0; wr_data = 8'h0;
        ld_en = 1'b0; ld_sel = 3'd0; ld_data = 8'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        look(16'h0000); chk("R10", {14'h0, mode}, 16'h0000); chk("R10", {15'h0, locked}, 16'h0);
        look(16'h0080); chk("R10", {8'h0, rd_data}, 16'h0000);
        look(16'h0085); chk("R10", {8'h0, rd_data}, 16'h0055);
        look(16'h0087); chk("R10", {8'h0, rd_data}, 16'h0000);

        // R11 preload configuration
        preload(3'd0, 8'h55); preload(3'd1, 8'hAA); preload(3'd2, 8'h3C);
        look(16'h0081); chk("R11", {8'h0, rd_data}, 16'h00AA);

        // table walk
        for (int i = 0; i < 18; i++) begin
            look(VEC[i][19:4]);
            chk("R1-table mode", {14'h0, mode}, {14'h0, VEC[i][3:2]});
            chk("R2-table locked", {15'h0, locked}, {15'h0, VEC[i][1]});
            chk("R9-table copy", {15'h0, copy_blk}, {15'h0, VEC[i][0]});
        end

        // R12 read of non-control address
        look(16'h0010); chk("R12", {8'h0, rd_data}, 16'h0000);

        // R4 write open byte 82h to 55h; page2 becomes WP, byte locks
        wr(16'h0082, 8'h55);
        chk("R4", {8'h0, rd_data}, 16'h0055);
        chk("R4", {14'h0, mode}, 16'h0003);
        look(16'h0040); chk("R4", {14'h0, mode}, 16'h0001);
        wr(16'h0082, 8'h00);
        chk("R4", {8'h0, rd_data}, 16'h0055);
        wr(16'h0080, 8'h12);
        chk("R4", {8'h0, rd_data}, 16'h0055);

        // R5 factory write ignored
        wr(16'h0085, 8'h12);
        chk("R5", {8'h0, rd_data}, 16'h0055);

        // R6 user bytes writable with factory 55h
        wr(16'h0086, 8'h5A);
        chk("R6", {8'h0, rd_data}, 16'h005A);
        preload(3'd5, 8'hAA);
        look(16'h0086);
        chk("R6", {14'h0, mode}, 16'h0003); chk("R6", {15'h0, locked}, 16'h0001);
        wr(16'h0086, 8'h11);
        chk("R6", {8'h0, rd_data}, 16'h005A);
        look(16'h0087); chk("R6", {15'h0, locked}, 16'h0001);

        // R7 write to reserved is ignored
        wr(16'h0088, 8'h77);
        chk("R7", {8'h0, rd_data}, 16'h0000);

        // R11 preload bypasses lock on 80h
        preload(3'd0, 8'h00);
        look(16'h0000); chk("R11", {14'h0, mode}, 16'h0000);
        preload(3'd0, 8'h55);

        // R9 copy protection via ordinary write to 84h
        wr(16'h0084, 8'hAA);
        chk("R9", {8'h0, rd_data}, 16'h00AA);
        chk("R9", {15'h0, locked}, 16'h0001);
        look(16'h0000); chk("R9", {15'h0, copy_blk}, 16'h0001);
        look(16'h0020); chk("R9", {15'h0, copy_blk}, 16'h0000);
        look(16'h0040); chk("R9", {15'h0, copy_blk}, 16'h0001);
        look(16'h0060); chk("R9", {15'h0, copy_blk}, 16'h0000);
        look(16'h0080); chk("R9", {15'h0, copy_blk}, 16'h0001);
        look(16'h008F); chk("R9", {15'h0, copy_blk}, 16'h0001);
        look(16'h0090); chk("R8", {15'h0, copy_blk}, 16'h0000);

        // R11 preload wins over simultaneous write
        @(negedge clk);
        addr = 16'h0083; wr_req = 1'b1; wr_data = 8'h01;
        ld_en = 1'b1; ld_sel = 3'd3; ld_data = 8'h22;
        @(negedge clk);
        wr_req = 1'b0; ld_en = 1'b0; #1;
        chk("R11", {8'h0, rd_data}, 16'h0022);

        done = 1'b1;
        finish_up();
    end
endmodule